// File: doc/BRIEF.md
# Dual-Window Local Bus Address Decoder

This block sits between a host bus and an 8-bit local bus. For each host transaction it decides whether the address falls into one of the local bus windows. If it does, it drives the matching active-low select line and the local address, both registered. Each of the two select lines has its own I/O window. The size of each I/O window is programmable as a power of two from 4 to 256 bytes. One fixed 4 KB memory window serves both select lines.

The two kinds of access are decoded differently. I/O accesses are byte-aligned: the local address is the low host address byte with the bits above the window size forced to zero. Memory accesses are DWORD-aligned. In a memory access, host address bit 10 picks the select line and bits [9:2] become the local address, so each select line's 256 local bytes cover 1 KB of host space.

Decoding happens only in local-bus mode. A signalling-style input chooses whether the two select outputs are to be read as chip selects or as data strobes. The decode does not change with this choice. The choice is registered onto a flag output that travels with the selects.

Top module: `lbus_addr_decode`

## Requirements
- R1: While reset is high and in the first cycle after it, cs_n is 2'b11, laddr is 0, hit is 0 and ds_mode is 0.
- R2: An I/O transaction (txn_is_io=1) whose address equals the window's base on every bit at or above the window size asserts that window's select, low, in the cycle after txn_valid. Bit 0 of cs_n is window 0 and bit 1 is window 1. hit is 1 in that same cycle.
- R3: Size code k (io_size0/io_size1) gives a window of 2^(k+2) bytes for k = 0..6, and code 7 is treated as 256 bytes. On an I/O hit, laddr equals txn_addr[7:0] with every bit at or above log2(size) cleared.
- R4: When an I/O address hits both windows, only window 0 is selected (cs_n = 2'b10).
- R5: A memory transaction (txn_is_io=0) whose txn_addr[31:12] equals mem_base_hi has an offset of txn_addr[11:0]. An offset of 000h–3FFh selects cs_n = 2'b10 and an offset of 400h–7FFh selects cs_n = 2'b01. laddr = txn_addr[9:2] and hit = 1.
- R6: A memory transaction at window offset 800h or above, or outside the 4 KB window, selects nothing and leaves hit at 0.
- R7: With lbus_mode = 0, no select is asserted and hit stays 0 for any transaction.
- R8: Outputs are idle (cs_n = 2'b11, laddr = 0, hit = 0) in every cycle that does not follow a valid, hitting transaction. A hit therefore lasts exactly one cycle per transaction.
- R9: At most one bit of cs_n is low at a time, and hit is 1 exactly when a bit of cs_n is low.
- R10: ds_mode registers strobe_style (1 = data-strobe signalling). strobe_style has no effect on cs_n, laddr or hit.
- R11: An I/O transaction is never decoded against the memory window, and a memory transaction is never decoded against the I/O windows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| txn_valid | input | 1 | Host transaction present this cycle |
| txn_is_io | input | 1 | 1 = I/O cycle, 0 = memory cycle |
| txn_addr | input | 32 | Host byte address |
| io_base0 | input | 32 | Base of I/O window 0 |
| io_base1 | input | 32 | Base of I/O window 1 |
| io_size0 | input | 3 | Size code of window 0 |
| io_size1 | input | 3 | Size code of window 1 |
| mem_base_hi | input | 20 | Upper address bits of the 4 KB memory window |
| lbus_mode | input | 1 | 1 = local bus decoding enabled |
| strobe_style | input | 1 | 1 = selects act as data strobes |
| cs_n | output | 2 | Active-low selects / strobes, registered |
| laddr | output | 8 | Local address, registered |
| hit | output | 1 | Registered decode hit |
| ds_mode | output | 1 | Registered signalling style |

## Verification
The embedded properties check the following on every cycle: the select lines are mutually exclusive, hit agrees with the select lines, outputs are idle after a cycle with no valid transaction or with the mode disabled, and a high-region memory offset never produces a hit. Several behaviours can only be shown by the bench scenarios with known expected values. These are the exact local address values under each window size, the choice of select line across the 3FCh/400h boundary, the priority of window 0 when the windows overlap, and the separation of I/O and memory decoding.

// File: rtl/lbus_dec_pkg.sv
package lbus_dec_pkg;
  // Width of the local bus address
  localparam int LB_AW = 8;
  // Number of select lines
  localparam int N_SEL = 2;
  // Log2 of the host span one select line occupies in memory space (DWORD access)
  localparam int SEL_SPAN_LOG2 = LB_AW + 2;
  // All select lines inactive
  localparam logic [N_SEL-1:0] SEL_IDLE = '1;
endpackage

// File: rtl/lbus_io_window.sv
module lbus_io_window
  import lbus_dec_pkg::*;
#(
  parameter int HADDR_W = 32,
  parameter int SZ_W    = 3
) (
  input  logic [HADDR_W-1:0] addr,
  input  logic [HADDR_W-1:0] base,
  input  logic [SZ_W-1:0]    size_code,
  output logic               hit,
  output logic [LB_AW-1:0]   laddr
);
  // log2 of window bytes, capped at the local bus width
  int unsigned               nbits;
  logic [HADDR_W-1:0]        low_mask;

  always_comb begin
    nbits = int'(size_code) + 2;
    if (nbits > LB_AW) nbits = LB_AW;
    low_mask = ~({HADDR_W{1'b1}} << nbits);
    hit      = ((addr ^ base) & ~low_mask) == '0;
    laddr    = addr[LB_AW-1:0] & low_mask[LB_AW-1:0];
  end
endmodule

// File: rtl/lbus_mem_window.sv
module lbus_mem_window
  import lbus_dec_pkg::*;
#(
  parameter int HADDR_W  = 32,
  parameter int WIN_LOG2 = 12
) (
  input  logic [HADDR_W-1:2]        addr_dw,
  input  logic [HADDR_W-1:WIN_LOG2] base_hi,
  output logic                      hit,
  output logic                      sel_hi,
  output logic [LB_AW-1:0]          laddr
);
  localparam int TOP_LOG2 = SEL_SPAN_LOG2 + 1;

  logic in_win;
  logic high_region;

  always_comb begin
    in_win      = addr_dw[HADDR_W-1:WIN_LOG2] == base_hi;
    high_region = |addr_dw[WIN_LOG2-1:TOP_LOG2];
    hit         = in_win && !high_region;
    sel_hi      = addr_dw[SEL_SPAN_LOG2];
    laddr       = addr_dw[SEL_SPAN_LOG2-1:2];
  end
endmodule

// File: rtl/lbus_addr_decode.sv
module lbus_addr_decode
  import lbus_dec_pkg::*;
#(
  parameter int HADDR_W  = 32,
  parameter int SZ_W     = 3,
  parameter int WIN_LOG2 = 12
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        txn_valid,
  input  logic                        txn_is_io,
  input  logic [HADDR_W-1:0]          txn_addr,
  input  logic [HADDR_W-1:0]          io_base0,
  input  logic [HADDR_W-1:0]          io_base1,
  input  logic [SZ_W-1:0]             io_size0,
  input  logic [SZ_W-1:0]             io_size1,
  input  logic [HADDR_W-WIN_LOG2-1:0] mem_base_hi,
  input  logic                        lbus_mode,
  input  logic                        strobe_style,
  output logic [N_SEL-1:0]            cs_n,
  output logic [LB_AW-1:0]            laddr,
  output logic                        hit,
  output logic                        ds_mode
);
  logic [HADDR_W-1:0] base_arr [N_SEL];
  logic [SZ_W-1:0]    size_arr [N_SEL];
  logic [N_SEL-1:0]   io_hit;
  logic [LB_AW-1:0]   io_la    [N_SEL];

  assign base_arr[0] = io_base0;
  assign base_arr[1] = io_base1;
  assign size_arr[0] = io_size0;
  assign size_arr[1] = io_size1;

  for (genvar g = 0; g < N_SEL; g++) begin : g_io
    lbus_io_window #(.HADDR_W(HADDR_W), .SZ_W(SZ_W)) win_i (
      .addr      (txn_addr),
      .base      (base_arr[g]),
      .size_code (size_arr[g]),
      .hit       (io_hit[g]),
      .laddr     (io_la[g])
    );
  end

  logic             mem_hit;
  logic             mem_sel_hi;
  logic [LB_AW-1:0] mem_la;

  lbus_mem_window #(.HADDR_W(HADDR_W), .WIN_LOG2(WIN_LOG2)) mem_i (
    .addr_dw (txn_addr[HADDR_W-1:2]),
    .base_hi (mem_base_hi),
    .hit     (mem_hit),
    .sel_hi  (mem_sel_hi),
    .laddr   (mem_la)
  );

  logic [N_SEL-1:0] cs_n_d;
  logic [LB_AW-1:0] laddr_d;

  // Selection: I/O windows by fixed priority (window 0 first), memory by region bit
  always_comb begin
    cs_n_d  = SEL_IDLE;
    laddr_d = '0;
    if (txn_valid && lbus_mode) begin
      if (txn_is_io) begin
        for (int i = N_SEL - 1; i >= 0; i--) begin
          if (io_hit[i]) begin
            cs_n_d    = SEL_IDLE;
            cs_n_d[i] = 1'b0;
            laddr_d   = io_la[i];
          end
        end
      end else if (mem_hit) begin
        cs_n_d             = SEL_IDLE;
        cs_n_d[mem_sel_hi] = 1'b0;
        laddr_d            = mem_la;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cs_n    <= SEL_IDLE;
      laddr   <= '0;
      hit     <= 1'b0;
      ds_mode <= 1'b0;
    end else begin
      cs_n    <= cs_n_d;
      laddr   <= laddr_d;
      hit     <= cs_n_d != SEL_IDLE;
      ds_mode <= strobe_style;
    end
  end

  // R9: selects are mutually exclusive
  a_r9_one_select: assert property (@(posedge clk) disable iff (rst)
    $countones(~cs_n) <= 1);

  // R9: hit flag agrees with the select lines
  a_r9_hit_matches_cs: assert property (@(posedge clk) disable iff (rst)
    hit == (cs_n != SEL_IDLE));

  // R7: no decode with local bus mode off
  a_r7_mode_off_idle: assert property (@(posedge clk) disable iff (rst)
    !lbus_mode |=> (cs_n == SEL_IDLE) && !hit);

  // R8: idle after a cycle without a valid transaction
  a_r8_no_valid_idle: assert property (@(posedge clk) disable iff (rst)
    !txn_valid |=> (cs_n == SEL_IDLE) && (laddr == '0));

  // R6: high region of the memory window never hits
  a_r6_mem_high_miss: assert property (@(posedge clk) disable iff (rst)
    (txn_valid && !txn_is_io && (txn_addr[HADDR_W-1:WIN_LOG2] == mem_base_hi)
     && (txn_addr[WIN_LOG2-1:SEL_SPAN_LOG2+1] != '0)) |=> !hit);

  // R11: memory cycle outside the memory window never hits
  a_r11_mem_outside_miss: assert property (@(posedge clk) disable iff (rst)
    (txn_valid && !txn_is_io && (txn_addr[HADDR_W-1:WIN_LOG2] != mem_base_hi))
    |=> !hit);
endmodule

// File: tb/lbus_addr_decode_tb.sv
module lbus_addr_decode_tb_top;
  logic        clk = 1'b0;
  logic        rst;
  logic        txn_valid, txn_is_io, lbus_mode, strobe_style;
  logic [31:0] txn_addr, io_base0, io_base1;
  logic [2:0]  io_size0, io_size1;
  logic [19:0] mem_base_hi;
  logic [1:0]  cs_n;
  logic [7:0]  laddr;
  logic        hit, ds_mode;

  int n_tests = 0;
  int n_fail  = 0;

  always #5 clk = ~clk;

  lbus_addr_decode dut_i (
    .clk(clk), .rst(rst), .txn_valid(txn_valid), .txn_is_io(txn_is_io),
    .txn_addr(txn_addr), .io_base0(io_base0), .io_base1(io_base1),
    .io_size0(io_size0), .io_size1(io_size1), .mem_base_hi(mem_base_hi),
    .lbus_mode(lbus_mode), .strobe_style(strobe_style),
    .cs_n(cs_n), .laddr(laddr), .hit(hit), .ds_mode(ds_mode)
  );

  typedef struct packed {
    logic        io;
    logic [31:0] addr;
    logic [1:0]  cs;
    logic [7:0]  la;
    logic        hit;
    logic [3:0]  req;
  } vec_t;

  // Windows: 0 at 378h/8 bytes, 1 at 778h/8 bytes, memory at FEB00000h
  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 32'h0000_037B, 2'b10, 8'h03, 1'b1, 4'd3},  // R3 window 0, low bits kept
    '{1'b1, 32'h0000_077D, 2'b01, 8'h05, 1'b1, 4'd2},  // R2 window 1
    '{1'b1, 32'h0000_0380, 2'b11, 8'h00, 1'b0, 4'd8},  // R8 miss
    '{1'b0, 32'hFEB0_0004, 2'b10, 8'h01, 1'b1, 4'd5},  // R5
    '{1'b0, 32'hFEB0_03FC, 2'b10, 8'hFF, 1'b1, 4'd5},  // R5 top of cs0
    '{1'b0, 32'hFEB0_0400, 2'b01, 8'h00, 1'b1, 4'd5},  // R5 base of cs1
    '{1'b0, 32'hFEB0_07FC, 2'b01, 8'hFF, 1'b1, 4'd5},  // R5 top of cs1
    '{1'b0, 32'hFEB0_0800, 2'b11, 8'h00, 1'b0, 4'd6},  // R6
    '{1'b0, 32'hFEB0_0FFC, 2'b11, 8'h00, 1'b0, 4'd6},  // R6
    '{1'b0, 32'hFEB0_1000, 2'b11, 8'h00, 1'b0, 4'd6},  // R6 outside window
    '{1'b0, 32'h0000_037B, 2'b11, 8'h00, 1'b0, 4'd11}, // R11 I/O address, memory cycle
    '{1'b1, 32'hFEB0_0004, 2'b11, 8'h00, 1'b0, 4'd11}, // R11 memory address, I/O cycle
    '{1'b0, 32'hFEB0_0107, 2'b10, 8'h41, 1'b1, 4'd5}   // R5 byte lanes dropped
  };

  task automatic check(input string req, input logic [1:0] ecs,
                       input logic [7:0] ela, input logic ehit, input logic eds);
    n_tests++;
    if (cs_n !== ecs || laddr !== ela || hit !== ehit || ds_mode !== eds) begin
      n_fail++;
      $display("FAIL %s: cs_n=%b laddr=%h hit=%b ds=%b, expected cs_n=%b laddr=%h hit=%b ds=%b",
               req, cs_n, laddr, hit, ds_mode, ecs, ela, ehit, eds);
    end
  endtask

  // One transaction; outputs sampled at the negedge after the capturing posedge
  task automatic txn(input logic io, input logic [31:0] a);
    @(negedge clk);
    txn_valid = 1'b1;
    txn_is_io = io;
    txn_addr  = a;
    @(negedge clk);
    txn_valid = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    rst = 1'b1; txn_valid = 1'b0; txn_is_io = 1'b1; txn_addr = '0;
    io_base0 = 32'h378; io_base1 = 32'h778; io_size0 = 3'd1; io_size1 = 3'd1;
    mem_base_hi = 20'hFEB00; lbus_mode = 1'b1; strobe_style = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 in reset", 2'b11, 8'h00, 1'b0, 1'b0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 after reset", 2'b11, 8'h00, 1'b0, 1'b0);

    for (int i = 0; i < NV; i++) begin
      txn(VECS[i].io, VECS[i].addr);
      check($sformatf("R%0d vector %0d", VECS[i].req, i),
            VECS[i].cs, VECS[i].la, VECS[i].hit, 1'b0);
    end

    // R8: a hit lasts one cycle
    txn(1'b1, 32'h37F);
    check("R2 hit", 2'b10, 8'h07, 1'b1, 1'b0);
    @(negedge clk);
    check("R8 one-cycle pulse", 2'b11, 8'h00, 1'b0, 1'b0);

    // R3: 256-byte window passes the full byte; code 7 behaves the same
    io_base0 = 32'h1200; io_size0 = 3'd6;
    txn(1'b1, 32'h12AB);
    check("R3 size 256", 2'b10, 8'hAB, 1'b1, 1'b0);
    io_size0 = 3'd7;
    txn(1'b1, 32'h12F1);
    check("R3 code 7", 2'b10, 8'hF1, 1'b1, 1'b0);
    // R3: 4-byte window
    io_size0 = 3'd0;
    txn(1'b1, 32'h1203);
    check("R3 size 4", 2'b10, 8'h03, 1'b1, 1'b0);
    txn(1'b1, 32'h1204);
    check("R3 size 4 miss", 2'b11, 8'h00, 1'b0, 1'b0);
    // R3: 32-byte window
    io_size0 = 3'd3;
    txn(1'b1, 32'h12FF);
    check("R3 size 32 miss", 2'b11, 8'h00, 1'b0, 1'b0);
    txn(1'b1, 32'h121F);
    check("R3 size 32", 2'b10, 8'h1F, 1'b1, 1'b0);

    // R4: overlap, window 0 wins
    io_base1 = 32'h1200; io_size0 = 3'd6; io_size1 = 3'd6;
    txn(1'b1, 32'h1255);
    check("R4 overlap", 2'b10, 8'h55, 1'b1, 1'b0);
    io_base0 = 32'h5000;
    txn(1'b1, 32'h1255);
    check("R4 window 1 alone", 2'b01, 8'h55, 1'b1, 1'b0);

    // R7: mode off
    lbus_mode = 1'b0;
    txn(1'b1, 32'h1255);
    check("R7 mode off io", 2'b11, 8'h00, 1'b0, 1'b0);
    txn(1'b0, 32'hFEB0_0400);
    check("R7 mode off mem", 2'b11, 8'h00, 1'b0, 1'b0);
    lbus_mode = 1'b1;

    // R8: matching address without txn_valid
    @(negedge clk);
    txn_is_io = 1'b0; txn_addr = 32'hFEB0_0400;
    @(negedge clk);
    check("R8 no valid", 2'b11, 8'h00, 1'b0, 1'b0);

    // R10: style flag registered, decode unchanged
    strobe_style = 1'b1;
    txn(1'b0, 32'hFEB0_0408);
    check("R10 strobe style", 2'b01, 8'h02, 1'b1, 1'b1);
    txn(1'b1, 32'h1210);
    check("R10 strobe style io", 2'b01, 8'h10, 1'b1, 1'b1);

    // R1: reset mid-run clears outputs
    @(negedge clk);
    txn_valid = 1'b1; txn_is_io = 1'b1; txn_addr = 32'h1210; rst = 1'b1;
    @(negedge clk);
    check("R1 reset overrides", 2'b11, 8'h00, 1'b0, 1'b0);
    txn_valid = 1'b0; rst = 1'b0;

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule